// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This block sits on the host side of an external audio codec and brings it from reset into PLL master mode without help from software. It drives the codec's active-low power-down line. It then issues a fixed, ordered script of 8-bit register writes through a generic request/acknowledge write port, which a separate serial-bus engine turns into bus traffic. Timed pauses separate the steps. Every pause is a cycle count derived from a reference-frequency parameter and rounded up, so no minimum time is ever cut short.

After the PLL-enable write, the block watches the codec's frame clock. It raises `ready` on the first rising edge. If no edge arrives within a lock window that is longer than the worst-case 5 ms lock time, it raises a sticky `timeout_err` instead. A request to change the master clock is accepted only in the ready or timeout state. The block then clears the power-management bits, PLL first and reference second. It waits for the new clock to be reported stable, and then replays the power-up steps from the reference enable onward.

States: `S_INIT` (load the reset-hold timer) → `S_HOLD` (power-down low until the timer expires) → `S_ISSUE` (request held until acknowledged) → `S_ADVANCE` (act on the step just written). From `S_ADVANCE` the block goes to one of: `S_ISSUE` (plain step), `S_WAIT_VREF` (reference settle, then `S_ISSUE`), `S_WAIT_LOCK` (frame-clock edge → `S_READY`, timer expiry → `S_TIMEOUT`) or `S_WAIT_MCLK` (clock stable → `S_ISSUE` at the reference-enable step). `S_READY` and `S_TIMEOUT` go to `S_ISSUE` at the first power-down step when a clock change is requested.

Top module: `codec_pwrup_seq`

## Requirements
- R1: From reset, `codec_pdn_n` is low for at least ceil(200 ns × REF_HZ) cycles (minimum 1). It then goes high and stays high until the next reset, including through clock changes.
- R2: The first write after `codec_pdn_n` rises is the dummy write, address 0x00 with data 0x00.
- R3: Next come four configuration writes in this order: 0x01←0x08, 0x05←0x62, 0x06←0x0B, 0x07←0x03. They are followed by the reference enable 0x00←0x40.
- R4: At least ceil(2 ms × REF_HZ) cycles pass between the acknowledge of 0x00←0x40 and the request of the PLL-enable write 0x01←0x0C.
- R5: `wr_req` stays high with stable `wr_addr`/`wr_data` until `wr_ack` is sampled high. Each acknowledge completes exactly one write, and `wr_req` is low for at least one cycle between writes.
- R6: After 0x01←0x0C is written, `ready` stays low until a rising edge is seen on `fck_in`. It goes high within 4 cycles after that edge, passing through a two-stage synchronizer.
- R7: If no `fck_in` rising edge arrives within ceil(6 ms × REF_HZ) cycles of the PLL-enable write, `timeout_err` rises. It stays high, with `ready` low, until a clock change is requested.
- R8: A `clk_chg_req` pulse in the ready or timeout state clears both flags and issues 0x01←0x08 then 0x00←0x00. No further write is issued until `mclk_stable` is high. The block then writes 0x00←0x40, waits as in R4, writes 0x01←0x0C, and waits for the frame clock as in R6/R7.
- R9: `clk_chg_req` has no effect in any state other than ready or timeout.
- R10: `ready` and `timeout_err` are never high together, and no write is requested while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| codec_pdn_n | output | 1 | Active-low power-down line to the codec |
| wr_req | output | 1 | Register write request, held until acknowledged |
| wr_addr | output | 8 | Codec register address of the pending write |
| wr_data | output | 8 | Data of the pending write |
| wr_ack | input | 1 | Write-complete acknowledge from the bus engine |
| fck_in | input | 1 | Codec frame clock, asynchronous |
| clk_chg_req | input | 1 | Request to power down for a master-clock change |
| mclk_stable | input | 1 | New master clock is stable |
| ready | output | 1 | Codec running in master mode |
| timeout_err | output | 1 | No frame clock seen within the lock window |

## Verification
The assertions assume the following about the inputs. `wr_ack` is high only while `wr_req` is high, and only for one cycle per write. `clk_chg_req` and `mclk_stable` are synchronous to `clk`. Reset is applied only while no write is in flight. The bench's write responder acknowledges one cycle-wide pulse per request after a programmable latency, and checks that the request drops before its next look. All bench inputs change on the falling edge. The reference frequency is reduced to 1 MHz so that the 2 ms and 6 ms windows become 2000 and 6000 cycles.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

    typedef enum logic [1:0] {
        ACT_NEXT,   // go straight to the following step
        ACT_VREF,   // settle the reference before the following step
        ACT_LOCK,   // wait for the frame clock
        ACT_PARK    // wait for a stable master clock
    } step_act_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        step_act_t  act;
    } step_t;

    typedef enum logic [3:0] {
        S_INIT,
        S_HOLD,
        S_ISSUE,
        S_ADVANCE,
        S_WAIT_VREF,
        S_WAIT_LOCK,
        S_READY,
        S_TIMEOUT,
        S_WAIT_MCLK
    } seq_state_t;

    localparam int unsigned STEP_COUNT     = 9;
    localparam int unsigned IDX_RESTART    = 5;   // reference enable
    localparam int unsigned IDX_POWER_DOWN = 7;   // first clock-change step

    // Round a duration in nanoseconds up to whole cycles, never below one.
    function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                     input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/seq_script_rom.sv
module seq_script_rom
    import codec_seq_pkg::*;
#(
    parameter int unsigned IDX_W    = 4,
    parameter logic [7:0]  MODE_CFG = 8'h08,
    parameter logic [7:0]  PLL_CFG  = 8'h62,
    parameter logic [7:0]  CLK_CFG  = 8'h0B,
    parameter logic [7:0]  FMT_CFG  = 8'h03
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    always_comb begin
        unique case (idx)
            IDX_W'(0): step = '{addr: 8'h00, data: 8'h00,     act: ACT_NEXT};
            IDX_W'(1): step = '{addr: 8'h01, data: MODE_CFG,  act: ACT_NEXT};
            IDX_W'(2): step = '{addr: 8'h05, data: PLL_CFG,   act: ACT_NEXT};
            IDX_W'(3): step = '{addr: 8'h06, data: CLK_CFG,   act: ACT_NEXT};
            IDX_W'(4): step = '{addr: 8'h07, data: FMT_CFG,   act: ACT_NEXT};
            IDX_W'(5): step = '{addr: 8'h00, data: 8'h40,     act: ACT_VREF};
            IDX_W'(6): step = '{addr: 8'h01, data: MODE_CFG | 8'h04, act: ACT_LOCK};
            IDX_W'(7): step = '{addr: 8'h01, data: MODE_CFG,  act: ACT_NEXT};
            IDX_W'(8): step = '{addr: 8'h00, data: 8'h00,     act: ACT_PARK};
            default:   step = '{addr: 8'h00, data: 8'h00,     act: ACT_PARK};
        endcase
    end

endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fck_rise_detect.sv
module fck_rise_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fck_async,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], fck_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/codec_pwrup_seq.sv
module codec_pwrup_seq
    import codec_seq_pkg::*;
#(
    parameter longint unsigned REF_HZ        = 50_000_000,
    parameter longint unsigned RST_HOLD_NS   = 200,
    parameter longint unsigned VREF_NS       = 2_000_000,
    parameter longint unsigned LOCK_LIMIT_NS = 6_000_000,
    parameter int unsigned     SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       codec_pdn_n,
    output logic       wr_req,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    input  logic       wr_ack,
    input  logic       fck_in,
    input  logic       clk_chg_req,
    input  logic       mclk_stable,
    output logic       ready,
    output logic       timeout_err
);

    localparam longint unsigned RST_CYC  = ns_to_cycles(RST_HOLD_NS, REF_HZ);
    localparam longint unsigned VREF_CYC = ns_to_cycles(VREF_NS, REF_HZ);
    localparam longint unsigned LOCK_CYC = ns_to_cycles(LOCK_LIMIT_NS, REF_HZ);
    localparam longint unsigned MAX_CYC  =
        (LOCK_CYC > VREF_CYC) ? ((LOCK_CYC > RST_CYC) ? LOCK_CYC : RST_CYC)
                              : ((VREF_CYC > RST_CYC) ? VREF_CYC : RST_CYC);
    localparam int unsigned     TMR_W    = $clog2(MAX_CYC + 1);
    localparam int unsigned     IDX_W    = $clog2(STEP_COUNT);

    seq_state_t       state_q, state_nxt;
    logic [IDX_W-1:0] idx_q, idx_nxt;
    step_t            step_cur;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_len;
    logic             tmr_expired;
    logic             fck_rise;

    seq_script_rom #(
        .IDX_W (IDX_W)
    ) i_rom (
        .idx  (idx_q),
        .step (step_cur)
    );

    seq_wait_timer #(
        .W (TMR_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

    fck_rise_detect #(
        .STAGES (SYNC_STAGES)
    ) i_fck (
        .clk       (clk),
        .rst_n     (rst_n),
        .fck_async (fck_in),
        .rise      (fck_rise)
    );

    // Next state, step index and timer control.
    always_comb begin
        state_nxt = state_q;
        idx_nxt   = idx_q;
        tmr_load  = 1'b0;
        tmr_len   = TMR_W'(LOCK_CYC);
        unique case (state_q)
            S_INIT: begin
                tmr_load  = 1'b1;
                tmr_len   = TMR_W'(RST_CYC);
                state_nxt = S_HOLD;
            end
            S_HOLD: begin
                if (tmr_expired) state_nxt = S_ISSUE;
            end
            S_ISSUE: begin
                if (wr_ack) state_nxt = S_ADVANCE;
            end
            S_ADVANCE: begin
                unique case (step_cur.act)
                    ACT_NEXT: begin
                        idx_nxt   = idx_q + IDX_W'(1);
                        state_nxt = S_ISSUE;
                    end
                    ACT_VREF: begin
                        tmr_load  = 1'b1;
                        tmr_len   = TMR_W'(VREF_CYC);
                        state_nxt = S_WAIT_VREF;
                    end
                    ACT_LOCK: begin
                        tmr_load  = 1'b1;
                        tmr_len   = TMR_W'(LOCK_CYC);
                        state_nxt = S_WAIT_LOCK;
                    end
                    ACT_PARK: begin
                        state_nxt = S_WAIT_MCLK;
                    end
                endcase
            end
            S_WAIT_VREF: begin
                if (tmr_expired) begin
                    idx_nxt   = idx_q + IDX_W'(1);
                    state_nxt = S_ISSUE;
                end
            end
            S_WAIT_LOCK: begin
                if (fck_rise) begin
                    state_nxt = S_READY;
                end else if (tmr_expired) begin
                    state_nxt = S_TIMEOUT;
                end
            end
            S_READY, S_TIMEOUT: begin
                if (clk_chg_req) begin
                    idx_nxt   = IDX_W'(IDX_POWER_DOWN);
                    state_nxt = S_ISSUE;
                end
            end
            S_WAIT_MCLK: begin
                if (mclk_stable) begin
                    idx_nxt   = IDX_W'(IDX_RESTART);
                    state_nxt = S_ISSUE;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_INIT;
            idx_q   <= '0;
        end else begin
            state_q <= state_nxt;
            idx_q   <= idx_nxt;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        codec_pdn_n = 1'b1;
        wr_req      = 1'b0;
        wr_addr     = 8'h00;
        wr_data     = 8'h00;
        ready       = 1'b0;
        timeout_err = 1'b0;
        unique case (state_q)
            S_INIT, S_HOLD: codec_pdn_n = 1'b0;
            S_ISSUE: begin
                wr_req  = 1'b1;
                wr_addr = step_cur.addr;
                wr_data = step_cur.data;
            end
            S_READY:   ready       = 1'b1;
            S_TIMEOUT: timeout_err = 1'b1;
            S_ADVANCE, S_WAIT_VREF, S_WAIT_LOCK, S_WAIT_MCLK: ;
        endcase
    end

endmodule

// File: rtl/codec_seq_checker.sv
module codec_seq_checker #(
    parameter longint unsigned VREF_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       codec_pdn_n,
    input logic       wr_req,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       wr_ack,
    input logic       clk_chg_req,
    input logic       ready,
    input logic       timeout_err
);

    logic        vref_armed_q;
    logic [31:0] vref_gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vref_armed_q <= 1'b0;
            vref_gap_q   <= '0;
        end else if (wr_req && wr_ack) begin
            vref_armed_q <= (wr_addr == 8'h00) && (wr_data == 8'h40);
            vref_gap_q   <= '0;
        end else if (vref_gap_q != 32'hFFFF_FFFF) begin
            vref_gap_q   <= vref_gap_q + 32'd1;
        end
    end

    // R1
    pdn_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> codec_pdn_n);

    // R1
    pdn_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        codec_pdn_n |=> codec_pdn_n);

    // R4
    vref_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vref_armed_q && wr_req) |-> (64'(vref_gap_q) >= VREF_CYC));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R5
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> !wr_req);

    // R7
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !clk_chg_req) |=> timeout_err);

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && timeout_err));

    // R10
    no_write_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready || timeout_err) |-> !wr_req);

endmodule

bind codec_pwrup_seq codec_seq_checker #(
    .VREF_CYC (VREF_CYC)
) i_codec_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .codec_pdn_n (codec_pdn_n),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_ack      (wr_ack),
    .clk_chg_req (clk_chg_req),
    .ready       (ready),
    .timeout_err (timeout_err)
);

// File: tb/test_codec_pwrup_seq.sv
module test_codec_pwrup_seq;

    localparam int VREF_TB = 2000;   // 2 ms at 1 MHz
    localparam int LOCK_TB = 6000;   // 6 ms at 1 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       codec_pdn_n, wr_req, wr_ack, ready, timeout_err;
    logic [7:0] wr_addr, wr_data;
    logic       fck_in = 1'b0, clk_chg_req = 1'b0, mclk_stable = 1'b0;

    int checks = 0, errors = 0, cyc = 0;
    int ack_lat = 2;
    int n_log = 0, gap_err = 0, stab_err = 0;
    logic [7:0] log_addr [0:63];
    logic [7:0] log_data [0:63];
    int         log_req  [0:63];
    int         log_ack  [0:63];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    codec_pwrup_seq #(.REF_HZ(1_000_000)) i_codec_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .codec_pdn_n(codec_pdn_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .fck_in(fck_in), .clk_chg_req(clk_chg_req), .mclk_stable(mclk_stable),
        .ready(ready), .timeout_err(timeout_err)
    );

    // Write responder: acknowledges each request after ack_lat cycles.
    initial begin
        wr_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && wr_req) begin
                automatic int         rq = cyc;
                automatic logic [7:0] a  = wr_addr;
                automatic logic [7:0] d  = wr_data;
                repeat (ack_lat) begin
                    @(negedge clk);
                    if (!wr_req || wr_addr != a || wr_data != d) stab_err++;
                end
                wr_ack = 1'b1;
                if (n_log < 64) begin
                    log_addr[n_log] = a; log_data[n_log] = d;
                    log_req[n_log]  = rq; log_ack[n_log] = cyc;
                end
                n_log++;
                @(negedge clk);
                wr_ack = 1'b0;
                if (wr_req) gap_err++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 20000 && n_log < n; i++) @(negedge clk);
    endtask

    task automatic chk_write(input int i, input logic [7:0] a, input logic [7:0] d,
                             input string req);
        chk(log_addr[i] == a, req, $sformatf("write %0d addr", i), log_addr[i], a);
        chk(log_data[i] == d, req, $sformatf("write %0d data", i), log_data[i], d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fck_in = 1'b0; clk_chg_req = 1'b0; mclk_stable = 1'b0;
        repeat (3) @(negedge clk);
        chk(codec_pdn_n == 1'b0, "R1", "pdn in reset", codec_pdn_n, 0);
        chk(wr_req == 1'b0, "R5", "req in reset", wr_req, 0);
        chk(ready == 1'b0 && timeout_err == 1'b0, "R10", "flags in reset",
            {ready, timeout_err}, 0);
        n_log = 0; gap_err = 0; stab_err = 0;
        rst_n = 1'b1;
    endtask

    task automatic fck_rise_and_check(input string req);
        chk(ready == 1'b0, req, "ready before frame edge", ready, 0);
        @(negedge clk); fck_in = 1'b1;
        repeat (5) @(negedge clk);
        chk(ready == 1'b1 && timeout_err == 1'b0, req, "ready after frame edge",
            {ready, timeout_err}, 2);
    endtask

    // R1 R2 R3 R4 R6 R10: plain power-up
    task automatic t_powerup();
        int low = 0;
        ack_lat = 3;
        do_reset();
        for (int i = 0; i < 100 && !codec_pdn_n; i++) begin
            low++; @(negedge clk);
        end
        chk(low >= 1 && codec_pdn_n, "R1", "pdn low then high", low, 1);
        wait_log(7);
        chk(n_log == 7, "R3", "write count", n_log, 7);
        chk_write(0, 8'h00, 8'h00, "R2");
        chk_write(1, 8'h01, 8'h08, "R3");
        chk_write(2, 8'h05, 8'h62, "R3");
        chk_write(3, 8'h06, 8'h0B, "R3");
        chk_write(4, 8'h07, 8'h03, "R3");
        chk_write(5, 8'h00, 8'h40, "R3");
        chk_write(6, 8'h01, 8'h0C, "R4");
        chk(log_req[6] - log_ack[5] >= VREF_TB, "R4", "reference settle gap",
            log_req[6] - log_ack[5], VREF_TB);
        repeat (10) @(negedge clk);
        fck_rise_and_check("R6");
        repeat (20) @(negedge clk);
        chk(n_log == 7, "R10", "no write while ready", n_log, 7);
        chk(gap_err == 0 && stab_err == 0, "R5", "handshake", gap_err + stab_err, 0);
    endtask

    // R5: slow acknowledge keeps the request held
    task automatic t_handshake();
        logic [7:0] a0;
        ack_lat = 40;
        do_reset();
        for (int i = 0; i < 100 && !wr_req; i++) @(negedge clk);
        a0 = wr_addr;
        repeat (25) @(negedge clk);
        chk(wr_req == 1'b1 && wr_addr == a0 && n_log == 0, "R5", "request held",
            {wr_req, wr_addr}, {1'b1, a0});
        wait_log(5);
        chk(gap_err == 0 && stab_err == 0, "R5", "stable and gapped",
            gap_err + stab_err, 0);
        chk_write(4, 8'h07, 8'h03, "R5");
    endtask

    // R9: change request during the reference wait is ignored
    task automatic t_ignored_change();
        ack_lat = 2;
        do_reset();
        wait_log(6);
        repeat (50) @(negedge clk);
        clk_chg_req = 1'b1;
        repeat (3) @(negedge clk);
        clk_chg_req = 1'b0;
        wait_log(7);
        chk_write(6, 8'h01, 8'h0C, "R9");
        repeat (30) @(negedge clk);
        chk(n_log == 7, "R9", "no power-down writes", n_log, 7);
        fck_rise_and_check("R9");
    endtask

    // R8: clock change from the ready state
    task automatic t_change_from_ready();
        int base = n_log;
        @(negedge clk); clk_chg_req = 1'b1;
        @(negedge clk); clk_chg_req = 1'b0; fck_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(ready == 1'b0, "R8", "ready drops", ready, 0);
        wait_log(base + 2);
        chk_write(base,     8'h01, 8'h08, "R8");
        chk_write(base + 1, 8'h00, 8'h00, "R8");
        repeat (100) @(negedge clk);
        chk(n_log == base + 2, "R8", "parked until clock stable", n_log, base + 2);
        chk(codec_pdn_n == 1'b1, "R1", "pdn high during change", codec_pdn_n, 1);
        mclk_stable = 1'b1;
        wait_log(base + 4);
        chk_write(base + 2, 8'h00, 8'h40, "R8");
        chk_write(base + 3, 8'h01, 8'h0C, "R8");
        chk(log_req[base + 3] - log_ack[base + 2] >= VREF_TB, "R8", "settle gap",
            log_req[base + 3] - log_ack[base + 2], VREF_TB);
        fck_rise_and_check("R8");
    endtask

    // R7: no frame clock, then recovery via a change request
    task automatic t_timeout();
        int base;
        ack_lat = 1;
        do_reset();
        wait_log(7);
        repeat (5000) @(negedge clk);
        chk(timeout_err == 1'b0 && ready == 1'b0, "R7", "no timeout before window",
            {ready, timeout_err}, 0);
        repeat (1100) @(negedge clk);
        chk(timeout_err == 1'b1 && ready == 1'b0, "R7", "timeout after window",
            {ready, timeout_err}, 1);
        repeat (50) @(negedge clk);
        chk(timeout_err == 1'b1 && n_log == 7, "R7", "timeout sticky", timeout_err, 1);
        base = n_log;
        mclk_stable = 1'b1;
        @(negedge clk); clk_chg_req = 1'b1;
        @(negedge clk); clk_chg_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(timeout_err == 1'b0, "R8", "timeout cleared", timeout_err, 0);
        wait_log(base + 4);
        chk_write(base,     8'h01, 8'h08, "R8");
        chk_write(base + 1, 8'h00, 8'h00, "R8");
        chk_write(base + 2, 8'h00, 8'h40, "R8");
        chk_write(base + 3, 8'h01, 8'h0C, "R8");
        fck_rise_and_check("R6");
    endtask

    bit done = 1'b0;

    initial begin
        t_powerup();
        t_change_from_ready();
        t_handshake();
        t_ignored_change();
        t_timeout();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule